// File: doc/BRIEF.md
# Dual-Slot I2C Control and Status Register Block

This block is the host-facing register port of a two-slot card interface. It is an I2C target with two bus addresses, one per card slot. Each slot has an 8-bit control byte, which the slot's sequencer and clock logic read. Each slot also has an 8-bit status byte, built from live levels and sticky event flags supplied by the sequencer and the protection logic. Two strap inputs move both addresses together, so up to four such devices can share one bus.

Every transfer carries exactly one byte. A write is START, address with R/W low, the control byte, then STOP. A read is START, address with R/W high, the status byte, then STOP. Reading a status byte clears the sticky flags that the byte reported. An active-low interrupt output is pulled low in two cases: while an unread event is pending in either slot, and while the supply supervisor is active.

SCL and SDA are sampled by the system clock through two-flop synchronisers. That clock must run at least eight times faster than SCL. SDA is never driven high. The block only asserts a pull-low enable.

Top module: `dual_slot_i2c_regs`

## Requirements
- R1: The 7-bit address of slot 1 is 0x20 + strap and that of slot 2 is 0x24 + strap, where strap = {strap_i[1], strap_i[0]}. These are write bytes 0x40/0x48 for strap 00 up to 0x46/0x4E for strap 11. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: An address that matches neither slot is not acknowledged. The block then ignores the bus until the next START, and neither control byte changes.
- R3: A write transfer stores its one data byte into the control byte of the addressed slot only, and that byte is acknowledged. Any further data byte in the same transfer is not acknowledged and changes nothing.
- R4: Both control bytes are 0x00 after reset. The control byte appears unchanged on ctrl1_o and ctrl2_o, with this bit map: bit0 session start, bit1 warm reset, bit2 3 V select, bit3 power-down, bit4 stop level, bits 6:5 clock divider, bit7 I/O pass-through.
- R5: A pulse on warm_clr_i[n] clears bit1 of that slot's control byte. If a bus write to the same slot lands in the same cycle, the written value wins.
- R6: A read returns the slot's status byte MSB first. The bits are: bit0 card present (live), bit1 presence changed, bit2 I/O level (live), bit3 supervisor fault, bit4 protection event, bit5 mute (live), bit6 early answer (live), bit7 slot active (live).
- R7: Bit1 sets on any change of present_i after reset. Bit4 sets on a prot_evt_i pulse. Bit3 is set out of reset and is set again while sup_active_i is high.
- R8: Bits 1, 3 and 4 are sticky. Each one that read as 1 is cleared when the master returns ACK or NACK for the status byte. An event that arrives in the clearing cycle keeps its bit set, and sup_active_i still high keeps bit3 set.
- R9: irq_n_o is low while, in either slot, bit1 or bit4 is set or a rising edge of mute_i or early_i has not yet been followed by a status read of that slot.
- R10: irq_n_o is low whenever sup_active_i is high.
- R11: sda_pull_o is asserted only during acknowledge bits and the zero bits of read data. It is released at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock level seen on the bus |
| sda_i | input | 1 | I2C data level seen on the bus |
| sda_pull_o | output | 1 | Pull-low enable for the SDA pad |
| strap_i | input | 2 | Address strap pins |
| sup_active_i | input | 1 | Supply supervisor active |
| present_i | input | 2 | Card present level, per slot |
| io_level_i | input | 2 | Card I/O line level, per slot |
| active_i | input | 2 | Slot session active, per slot |
| mute_i | input | 2 | Mute flag from the sequencer, per slot |
| early_i | input | 2 | Early answer flag from the sequencer, per slot |
| prot_evt_i | input | 2 | Protection event pulse, per slot |
| warm_clr_i | input | 2 | Warm-reset done pulse, per slot |
| ctrl1_o | output | 8 | Control byte of slot 1 |
| ctrl2_o | output | 8 | Control byte of slot 2 |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Writes are applied for every strap setting to both slots, using data patterns with different bit weights. A decode that mixes up strap and slot bits, or that writes both slots at once, therefore shows as a wrong byte on the other port. Foreign addresses, including the partner address of another strap setting, show whether decoding is exact. A two-byte write shows whether the second byte is refused.

Status reads are taken twice in a row after each event source: presence change, protection pulse, mute edge and supervisor activity. The first read shows that the flag was captured. The second read shows that the read cleared only the sticky bits while the live bits stayed. The interrupt level is compared before and after each read.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK, S_WAIT
  } bus_st_t;

  localparam int ST_PRES  = 0;
  localparam int ST_PCHG  = 1;
  localparam int ST_IO    = 2;
  localparam int ST_SUPF  = 3;
  localparam int ST_PROT  = 4;
  localparam int ST_MUTE  = 5;
  localparam int ST_EARLY = 6;
  localparam int ST_ACT   = 7;
  localparam int CT_WARM  = 1;
endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cr_bus_fsm.sv
`timescale 1ns/1ps
module i2cr_bus_fsm
  import i2cr_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h20,
  parameter int SLOT_BIT = 2,
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [7:0]         stat1,
  input  logic [7:0]         stat2,
  output logic               sda_pull,
  output logic [1:0]         wr_stb,
  output logic [7:0]         wr_data,
  output logic [1:0]         rd_done,
  output logic [7:0]         rd_snap,
  output bus_st_t            bus_st
);
  localparam logic [6:0] SLOT_OFS = 7'(1) << SLOT_BIT;

  logic       scl_q, sda_q;
  bus_st_t    st, st_n;
  logic [2:0] cnt, cnt_n;
  logic [7:0] sh, sh_n, snap, snap_n;
  logic       slot, slot_n, rw, rw_n, drv, drv_n;
  logic [1:0] wr_c, rd_c;

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_in = {sh[6:0], sda_s};
  wire [6:0] addr1 = ADDR_BASE | 7'(strap);
  wire [6:0] addr2 = ADDR_BASE | SLOT_OFS | 7'(strap);
  wire hit1 = (byte_in[7:1] == addr1);
  wire hit2 = (byte_in[7:1] == addr2);
  wire [7:0] stat_sel = slot ? stat2 : stat1;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; snap_n = snap;
    slot_n = slot; rw_n = rw; drv_n = drv;
    wr_c = 2'b00; rd_c = 2'b00;
    if (stop_c) begin
      st_n = S_IDLE; drv_n = 1'b0;
    end else if (start_c) begin
      st_n = S_ADDR; cnt_n = 3'd0; drv_n = 1'b0;
    end else begin
      case (st)
        S_ADDR: if (scl_rise) begin
          sh_n = byte_in; cnt_n = cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (hit1 | hit2) begin
              slot_n = hit2; rw_n = sda_s; st_n = S_AACK;
            end else begin
              st_n = S_WAIT;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (!drv) drv_n = 1'b1;
          else begin
            cnt_n = 3'd0;
            if (rw) begin
              st_n = S_RDATA; sh_n = stat_sel; snap_n = stat_sel;
              drv_n = ~stat_sel[7];
            end else begin
              st_n = S_WDATA; drv_n = 1'b0;
            end
          end
        end
        S_WDATA: if (scl_rise) begin
          sh_n = byte_in; cnt_n = cnt + 3'd1;
          if (cnt == 3'd7) st_n = S_WACK;
        end
        S_WACK: if (scl_fall) begin
          if (!drv) begin
            drv_n = 1'b1; wr_c[slot] = 1'b1;
          end else begin
            drv_n = 1'b0; st_n = S_WAIT;
          end
        end
        S_RDATA: if (scl_fall) begin
          if (cnt == 3'd7) begin
            drv_n = 1'b0; st_n = S_RACK;
          end else begin
            sh_n = {sh[6:0], 1'b0}; drv_n = ~sh[6]; cnt_n = cnt + 3'd1;
          end
        end
        S_RACK: if (scl_rise) begin
          rd_c[slot] = 1'b1; st_n = S_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; st <= S_IDLE; cnt <= 3'd0;
      sh <= 8'h00; snap <= 8'h00; slot <= 1'b0; rw <= 1'b0; drv <= 1'b0;
      wr_stb <= 2'b00; rd_done <= 2'b00;
    end else begin
      scl_q <= scl_s; sda_q <= sda_s; st <= st_n; cnt <= cnt_n;
      sh <= sh_n; snap <= snap_n; slot <= slot_n; rw <= rw_n; drv <= drv_n;
      wr_stb <= wr_c; rd_done <= rd_c;
    end
  end

  assign sda_pull = drv;
  assign wr_data  = sh;
  assign rd_snap  = snap;
  assign bus_st   = st;
endmodule

// File: rtl/i2cr_slot.sv
`timescale 1ns/1ps
module i2cr_slot
  import i2cr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       rd_done,
  input  logic [2:0] clr_mask,
  input  logic       warm_clr,
  input  logic       present,
  input  logic       io_lvl,
  input  logic       active,
  input  logic       mute,
  input  logic       early,
  input  logic       prot_evt,
  input  logic       sup_active,
  output logic [7:0] ctrl,
  output logic [7:0] status,
  output logic       irq_req
);
  logic [7:0] ctrl_n;
  logic pres_q, primed, pchg, prot, supf, mute_q, early_q, mute_p, early_p;
  logic pchg_n, prot_n, supf_n, mute_p_n, early_p_n;

  wire pchg_set  = primed & (present ^ pres_q);
  wire mute_rise = mute & ~mute_q;
  wire early_rise = early & ~early_q;
  wire clr_pchg = rd_done & clr_mask[0];
  wire clr_supf = rd_done & clr_mask[1];
  wire clr_prot = rd_done & clr_mask[2];

  always_comb begin
    ctrl_n = ctrl;
    if (wr_stb) ctrl_n = wr_data;
    else if (warm_clr) ctrl_n[CT_WARM] = 1'b0;
    pchg_n    = pchg_set   | (pchg & ~clr_pchg);
    prot_n    = prot_evt   | (prot & ~clr_prot);
    supf_n    = sup_active | (supf & ~clr_supf);
    mute_p_n  = mute_rise  | (mute_p & ~rd_done);
    early_p_n = early_rise | (early_p & ~rd_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= 8'h00; pres_q <= 1'b0; primed <= 1'b0; pchg <= 1'b0;
      prot <= 1'b0; supf <= 1'b1; mute_q <= 1'b0; early_q <= 1'b0;
      mute_p <= 1'b0; early_p <= 1'b0;
    end else begin
      ctrl <= ctrl_n; pres_q <= present; primed <= 1'b1; pchg <= pchg_n;
      prot <= prot_n; supf <= supf_n; mute_q <= mute; early_q <= early;
      mute_p <= mute_p_n; early_p <= early_p_n;
    end
  end

  always_comb begin
    status = 8'h00;
    status[ST_PRES]  = present;
    status[ST_PCHG]  = pchg;
    status[ST_IO]    = io_lvl;
    status[ST_SUPF]  = supf;
    status[ST_PROT]  = prot;
    status[ST_MUTE]  = mute;
    status[ST_EARLY] = early;
    status[ST_ACT]   = active;
  end

  assign irq_req = pchg | prot | mute_p | early_p;
endmodule

// File: rtl/dual_slot_i2c_regs.sv
`timescale 1ns/1ps
module dual_slot_i2c_regs
  import i2cr_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h20,
  parameter int SLOT_BIT = 2,
  parameter int STRAP_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sup_active_i,
  input  logic [1:0]         present_i,
  input  logic [1:0]         io_level_i,
  input  logic [1:0]         active_i,
  input  logic [1:0]         mute_i,
  input  logic [1:0]         early_i,
  input  logic [1:0]         prot_evt_i,
  input  logic [1:0]         warm_clr_i,
  output logic [7:0]         ctrl1_o,
  output logic [7:0]         ctrl2_o,
  output logic               irq_n_o
);
  localparam int NSLOT = 2;

  logic [1:0] bus_s;
  logic [1:0] wr_stb, rd_done, irq_req;
  logic [7:0] wr_data, rd_snap;
  logic [7:0] ctrl_w [NSLOT];
  logic [7:0] stat_w [NSLOT];
  logic [2:0] clr_mask;
  bus_st_t    bus_st;

  i2cr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  i2cr_bus_fsm #(.ADDR_BASE(ADDR_BASE), .SLOT_BIT(SLOT_BIT), .STRAP_W(STRAP_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .strap(strap_i), .stat1(stat_w[0]), .stat2(stat_w[1]),
    .sda_pull(sda_pull_o), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_done(rd_done), .rd_snap(rd_snap), .bus_st(bus_st)
  );

  assign clr_mask = {rd_snap[ST_PROT], rd_snap[ST_SUPF], rd_snap[ST_PCHG]};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    i2cr_slot u_slot (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb[g]), .wr_data(wr_data),
      .rd_done(rd_done[g]), .clr_mask(clr_mask), .warm_clr(warm_clr_i[g]),
      .present(present_i[g]), .io_lvl(io_level_i[g]), .active(active_i[g]),
      .mute(mute_i[g]), .early(early_i[g]), .prot_evt(prot_evt_i[g]),
      .sup_active(sup_active_i), .ctrl(ctrl_w[g]), .status(stat_w[g]),
      .irq_req(irq_req[g])
    );
  end

  assign ctrl1_o = ctrl_w[0];
  assign ctrl2_o = ctrl_w[1];
  assign irq_n_o = ~(|irq_req | sup_active_i);
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker
  import i2cr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_o,
  input logic       irq_n_o,
  input logic       sup_active_i,
  input logic [1:0] warm_clr_i,
  input logic [1:0] wr_stb,
  input logic [1:0] rd_done,
  input logic [7:0] ctrl1_o,
  input logic [7:0] stat1,
  input logic [7:0] stat2,
  input bus_st_t    bus_st
);
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb[0] && !warm_clr_i[0]) |=> $stable(ctrl1_o));

  assert_warm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_clr_i[0] && !wr_stb[0]) |=> !ctrl1_o[1]);

  assert_pchg_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1[1] && !rd_done[0]) |=> stat1[1]);

  assert_prot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat2[4] && !rd_done[1]) |=> stat2[4]);

  assert_irq_sup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sup_active_i |-> !irq_n_o);

  assert_pull_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (bus_st != S_IDLE));

  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((|wr_stb) && (|rd_done)));
endmodule

bind dual_slot_i2c_regs i2cr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .irq_n_o(irq_n_o),
  .sup_active_i(sup_active_i), .warm_clr_i(warm_clr_i), .wr_stb(wr_stb),
  .rd_done(rd_done), .ctrl1_o(ctrl1_o), .stat1(stat_w[0]), .stat2(stat_w[1]),
  .bus_st(bus_st)
);

// File: tb/tb_dual_slot_i2c_regs.sv
`timescale 1ns/1ps
module tb_dual_slot_i2c_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WD_CYCLES = 150000;
  localparam int NVEC = 6;
  // {strap[1:0], slot, data[7:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 8'h01}, {2'b00, 1'b1, 8'h84}, {2'b01, 1'b0, 8'h5A},
    {2'b10, 1'b1, 8'hA5}, {2'b11, 1'b0, 8'hFE}, {2'b11, 1'b1, 8'h30}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, irq_n, sup_active = 1'b0;
  logic [1:0] strap = 2'b00, present = 2'b01, io_lvl = 2'b11, active = 2'b00;
  logic [1:0] mute = 2'b00, early = 2'b00, prot = 2'b00, warm_clr = 2'b00;
  logic [7:0] ctrl1, ctrl2;
  logic [7:0] exp_c [2];
  int checks = 0, errors = 0;
  logic done = 1'b0;
  wire sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slot_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .strap_i(strap), .sup_active_i(sup_active), .present_i(present),
    .io_level_i(io_lvl), .active_i(active), .mute_i(mute), .early_i(early),
    .prot_evt_i(prot), .warm_clr_i(warm_clr), .ctrl1_o(ctrl1), .ctrl2_o(ctrl2),
    .irq_n_o(irq_n)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; qwait();
    scl = 1'b1; qwait();
    r = sda_line; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic r;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, r);
      d = {d[6:0], r};
    end
    bit_io(1'b1, r);
  endtask

  task automatic wr_reg(input logic [6:0] a7, input logic [7:0] d, output logic aa, output logic da);
    i2c_start();
    send_byte({a7, 1'b0}, aa);
    da = 1'b0;
    if (aa) send_byte(d, da);
    i2c_stop();
    cyc(4);
  endtask

  task automatic rd_reg(input logic [6:0] a7, output logic aa, output logic [7:0] d);
    i2c_start();
    send_byte({a7, 1'b1}, aa);
    d = 8'hFF;
    if (aa) recv_byte(d);
    i2c_stop();
    cyc(4);
  endtask

  initial begin
    logic aa, da;
    logic [7:0] d;
    exp_c[0] = 8'h00; exp_c[1] = 8'h00;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    // R4 reset state
    chk(ctrl1, 8'h00, "R4 ctrl1 reset");
    chk(ctrl2, 8'h00, "R4 ctrl2 reset");
    chk({7'd0, irq_n}, 8'h01, "R9 irq idle after reset");
    chk({7'd0, sda_pull}, 8'h00, "R11 no pull at idle");

    // R1 R3 vector walk over straps and slots
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] sv;
      logic sl;
      logic [7:0] dv;
      sv = VEC[v][10:9]; sl = VEC[v][8]; dv = VEC[v][7:0];
      strap = sv;
      cyc(2);
      wr_reg(7'h20 + {4'd0, sl, sv}, dv, aa, da);
      exp_c[sl] = dv;
      chk({7'd0, aa}, 8'h01, "R1 address ack");
      chk({7'd0, da}, 8'h01, "R3 data ack");
      chk(ctrl1, exp_c[0], "R3 ctrl1 after write");
      chk(ctrl2, exp_c[1], "R3 ctrl2 after write");
    end
    strap = 2'b00;
    cyc(2);

    // R2 foreign addresses
    wr_reg(7'h28, 8'hFF, aa, da);
    chk({7'd0, aa}, 8'h00, "R2 foreign 0x28 nack");
    wr_reg(7'h23, 8'hFF, aa, da);
    chk({7'd0, aa}, 8'h00, "R2 other strap addr nack");
    chk(ctrl1, exp_c[0], "R2 ctrl1 untouched");
    chk(ctrl2, exp_c[1], "R2 ctrl2 untouched");

    // R3 second data byte refused
    i2c_start();
    send_byte(8'h40, aa);
    send_byte(8'h11, da);
    chk({7'd0, da}, 8'h01, "R3 first byte ack");
    send_byte(8'h77, da);
    chk({7'd0, da}, 8'h00, "R3 second byte nack");
    i2c_stop();
    cyc(4);
    exp_c[0] = 8'h11;
    chk(ctrl1, 8'h11, "R3 only first byte stored");

    // R5 warm clear
    wr_reg(7'h20, 8'h03, aa, da);
    chk(ctrl1, 8'h03, "R5 warm set by write");
    warm_clr = 2'b01; cyc(1); warm_clr = 2'b00; cyc(2);
    chk(ctrl1, 8'h01, "R5 warm cleared by pulse");
    chk(ctrl2, exp_c[1], "R5 other slot unchanged");

    // R6 R8 first read shows supervisor fault, second does not
    rd_reg(7'h20, aa, d);
    chk({7'd0, aa}, 8'h01, "R1 read address ack");
    chk(d, 8'h0D, "R6 slot1 status after reset");
    rd_reg(7'h20, aa, d);
    chk(d, 8'h05, "R8 supervisor bit cleared by read");

    // R7 R9 presence change slot 2
    present = 2'b11; cyc(3);
    chk({7'd0, irq_n}, 8'h00, "R9 irq low on presence change");
    rd_reg(7'h24, aa, d);
    chk(d, 8'h0F, "R7 presence change captured");
    chk({7'd0, irq_n}, 8'h01, "R9 irq released after read");
    rd_reg(7'h24, aa, d);
    chk(d, 8'h05, "R8 presence change cleared");

    // R7 protection pulse slot 1 with active
    active = 2'b01;
    prot = 2'b01; cyc(1); prot = 2'b00; cyc(2);
    chk({7'd0, irq_n}, 8'h00, "R9 irq low on protection");
    rd_reg(7'h20, aa, d);
    chk(d, 8'h95, "R6 R7 protection and active bits");
    chk({7'd0, irq_n}, 8'h01, "R9 irq released after prot read");
    rd_reg(7'h20, aa, d);
    chk(d, 8'h85, "R8 protection cleared, active live");

    // R9 mute edge slot 2
    mute = 2'b10; cyc(3);
    chk({7'd0, irq_n}, 8'h00, "R9 irq low on mute edge");
    rd_reg(7'h24, aa, d);
    chk(d, 8'h25, "R6 mute level reported");
    chk({7'd0, irq_n}, 8'h01, "R9 irq released after mute read");
    rd_reg(7'h24, aa, d);
    chk(d, 8'h25, "R6 mute stays while level high");
    chk({7'd0, irq_n}, 8'h01, "R9 irq stays high without new edge");

    // R10 supervisor active
    sup_active = 1'b1; cyc(10);
    chk({7'd0, irq_n}, 8'h00, "R10 irq low while supervisor active");
    sup_active = 1'b0; cyc(3);
    chk({7'd0, irq_n}, 8'h01, "R10 irq high after supervisor");
    rd_reg(7'h20, aa, d);
    chk(d, 8'h8D, "R7 supervisor fault set again");
    rd_reg(7'h20, aa, d);
    chk(d, 8'h85, "R8 supervisor fault cleared");
    chk({7'd0, sda_pull}, 8'h00, "R11 released after stop");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule